// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block holds thirty-two 32-bit words as two banks of sixteen and lets an execution unit reach them through logical names instead of physical addresses. A one-bit bank selector decides which bank is the active one. The normal views (single word, aligned pair, aligned quad) land in the active bank. The extended views (single word, aligned pair) land in the other bank. Flipping the selector therefore swaps the roles of the two banks without moving any data.

There are two combinational read ports and one write port. Each port takes a view code and a 4-bit logical index. The write port stores one, two or four words in a single edge, depending on the view. A separate output always presents the whole inactive bank as a 4×4 matrix in column order, for use by a matrix-vector operation. An index that does not fit its view's alignment raises a flag. A write with such an index is dropped.

Top module: `banked_fpr_file`

## Requirements
- R1: A synchronous active-high reset clears all 32 words and the bank selector to zero.
- R2: View code 0 (single) with index i reaches bank 0 word i when the selector is 0, and bank 1 word i when it is 1. The word appears on read bits 31:0, with the upper read bits zero.
- R3: View code 3 (extended single) with index i reaches the bank opposite to the selector, word i.
- R4: View code 1 (pair) with even index n combines active-bank words n and n+1 on read bits 63:0, with word n in bits 63:32. View code 4 (extended pair) does the same on the opposite bank.
- R5: View code 2 (quad) with index n in {0,4,8,12} presents active-bank words n..n+3 on read bits 127:0, with word n in bits 127:96 and word n+3 in bits 31:0.
- R6: The matrix output holds 16 elements of 32 bits. Element (row r, column c) sits at flat position k = 4r+c, in bits 511-32k down to 480-32k, and carries opposite-bank word r+4c.
- R7: An odd index in a pair view, an index not a multiple of 4 in the quad view, or a view code of 5, 6 or 7 raises that port's misalignment flag. A read port with the flag raised returns all zeros.
- R8: A write whose access raises the write misalignment flag changes no stored word.
- R9: A write stores 1, 2 or 4 words on the rising edge, taking data from wr_data with the same bit layout as a read of that view. A read of the same location in the same cycle returns the value held before the write.
- R10: A bank-selector load takes effect at the next rising edge. Accesses in the same cycle as the load still use the old selector value.
- R11: The two read ports work independently and can read different views and indices in the same cycle.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_ld | input | 1 | Load the bank selector |
| bank_d | input | 1 | New bank selector value |
| bank_q | output | 1 | Current bank selector |
| wr_en | input | 1 | Write request |
| wr_view | input | 3 | Write view code |
| wr_idx | input | 4 | Write logical index |
| wr_data | input | 128 | Write data, laid out as a read of the view |
| wr_misalign | output | 1 | Write access misaligned or illegal view |
| rd0_view | input | 3 | Read port 0 view code |
| rd0_idx | input | 4 | Read port 0 logical index |
| rd0_data | output | 128 | Read port 0 data |
| rd0_misalign | output | 1 | Read port 0 misaligned |
| rd1_view | input | 3 | Read port 1 view code |
| rd1_idx | input | 4 | Read port 1 logical index |
| rd1_data | output | 128 | Read port 1 data |
| rd1_misalign | output | 1 | Read port 1 misaligned |
| mtx_data | output | 512 | Opposite bank as a 4×4 matrix, in column order |

## Verification
Two kinds of event can meet in one cycle. The first is a write and a read of the same word. The bench writes a word while a read port addresses it, checks before the edge that the old value is still seen, and checks after the edge that the new value is seen. The second is a bank-selector load together with an access. A read issued in the same cycle as the load must still follow the old mapping, and must switch to the new mapping, for both normal and extended views, only after the edge.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
    localparam int WORD_W     = 32;
    localparam int BANK_WORDS = 16;
    localparam int NUM_BANKS  = 2;
    localparam int PHYS_WORDS = BANK_WORDS * NUM_BANKS;
    localparam int IDX_W      = $clog2(BANK_WORDS);
    localparam int PHYS_W     = $clog2(PHYS_WORDS);
    localparam int MAX_WORDS  = 4;
    localparam int LANE_W     = WORD_W * MAX_WORDS;
    localparam int MTX_DIM    = 4;
    localparam int MTX_W      = WORD_W * BANK_WORDS;
    localparam int CNT_W      = 3;

    typedef enum logic [2:0] {
        VIEW_SGL   = 3'd0,
        VIEW_PAIR  = 3'd1,
        VIEW_QUAD  = 3'd2,
        VIEW_XSGL  = 3'd3,
        VIEW_XPAIR = 3'd4
    } view_e;

    typedef logic [PHYS_WORDS-1:0][WORD_W-1:0] store_t;

    typedef struct packed {
        logic [PHYS_W-1:0] base;
        logic [CNT_W-1:0]  nwords;
        logic              bad;
    } acc_t;

    function automatic acc_t decode_access(logic [2:0] view, logic [IDX_W-1:0] idx, logic bank);
        acc_t a;
        logic ext;
        ext      = 1'b0;
        a.nwords = CNT_W'(1);
        a.bad    = 1'b0;
        case (view)
            VIEW_SGL:   ;
            VIEW_PAIR:  begin a.nwords = CNT_W'(2); a.bad = idx[0]; end
            VIEW_QUAD:  begin a.nwords = CNT_W'(4); a.bad = |idx[1:0]; end
            VIEW_XSGL:  ext = 1'b1;
            VIEW_XPAIR: begin ext = 1'b1; a.nwords = CNT_W'(2); a.bad = idx[0]; end
            default:    a.bad = 1'b1;
        endcase
        a.base = {bank ^ ext, idx};
        return a;
    endfunction
endpackage

// File: rtl/fprf_decode.sv
module fprf_decode
    import fprf_pkg::*;
(
    input  logic [2:0]       view,
    input  logic [IDX_W-1:0] idx,
    input  logic             bank,
    output acc_t             acc
);
    always_comb acc = decode_access(view, idx, bank);
endmodule

// File: rtl/fprf_rdmux.sv
module fprf_rdmux
    import fprf_pkg::*;
(
    input  store_t            mem,
    input  acc_t              acc,
    output logic [LANE_W-1:0] data
);
    always_comb begin
        data = '0;
        if (!acc.bad) begin
            for (int w = 0; w < MAX_WORDS; w++) begin
                if (w < int'(acc.nwords)) begin
                    data[(int'(acc.nwords) - 1 - w) * WORD_W +: WORD_W] = mem[acc.base + PHYS_W'(w)];
                end
            end
        end
    end
endmodule

// File: rtl/fprf_store.sv
module fprf_store
    import fprf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  acc_t              acc,
    input  logic [LANE_W-1:0] wdata,
    output store_t            mem_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else if (we && !acc.bad) begin
            for (int w = 0; w < MAX_WORDS; w++) begin
                if (w < int'(acc.nwords)) begin
                    mem_q[acc.base + PHYS_W'(w)] <= wdata[(int'(acc.nwords) - 1 - w) * WORD_W +: WORD_W];
                end
            end
        end
    end
endmodule

// File: rtl/fprf_mtx.sv
module fprf_mtx
    import fprf_pkg::*;
(
    input  store_t           mem,
    input  logic             bank,
    output logic [MTX_W-1:0] mtx
);
    for (genvar r = 0; r < MTX_DIM; r++) begin : g_row
        for (genvar c = 0; c < MTX_DIM; c++) begin : g_col
            localparam int K   = r * MTX_DIM + c;
            localparam int SRC = r + MTX_DIM * c;
            assign mtx[MTX_W - 1 - K * WORD_W -: WORD_W] = mem[{~bank, IDX_W'(SRC)}];
        end
    end
endmodule

// File: rtl/banked_fpr_file.sv
module banked_fpr_file
    import fprf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bank_ld,
    input  logic               bank_d,
    output logic               bank_q,
    input  logic               wr_en,
    input  logic [2:0]         wr_view,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [LANE_W-1:0]  wr_data,
    output logic               wr_misalign,
    input  logic [2:0]         rd0_view,
    input  logic [IDX_W-1:0]   rd0_idx,
    output logic [LANE_W-1:0]  rd0_data,
    output logic               rd0_misalign,
    input  logic [2:0]         rd1_view,
    input  logic [IDX_W-1:0]   rd1_idx,
    output logic [LANE_W-1:0]  rd1_data,
    output logic               rd1_misalign,
    output logic [MTX_W-1:0]   mtx_data
);
    store_t mem_q;
    acc_t   wr_acc, rd0_acc, rd1_acc;

    always_ff @(posedge clk) begin
        if (rst)          bank_q <= 1'b0;
        else if (bank_ld) bank_q <= bank_d;
    end

    fprf_decode u_dec_wr  (.view(wr_view),  .idx(wr_idx),  .bank(bank_q), .acc(wr_acc));
    fprf_decode u_dec_rd0 (.view(rd0_view), .idx(rd0_idx), .bank(bank_q), .acc(rd0_acc));
    fprf_decode u_dec_rd1 (.view(rd1_view), .idx(rd1_idx), .bank(bank_q), .acc(rd1_acc));

    fprf_store u_store (
        .clk(clk), .rst(rst), .we(wr_en), .acc(wr_acc), .wdata(wr_data), .mem_q(mem_q)
    );

    fprf_rdmux u_rd0 (.mem(mem_q), .acc(rd0_acc), .data(rd0_data));
    fprf_rdmux u_rd1 (.mem(mem_q), .acc(rd1_acc), .data(rd1_data));

    fprf_mtx u_mtx (.mem(mem_q), .bank(bank_q), .mtx(mtx_data));

    assign wr_misalign  = wr_acc.bad;
    assign rd0_misalign = rd0_acc.bad;
    assign rd1_misalign = rd1_acc.bad;
endmodule

// File: rtl/banked_fpr_file_chk.sv
module banked_fpr_file_chk
    import fprf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bank_ld,
    input logic              bank_d,
    input logic              bank_q,
    input logic              wr_en,
    input logic              wr_misalign,
    input logic [LANE_W-1:0] rd0_data,
    input logic              rd0_misalign,
    input logic [LANE_W-1:0] rd1_data,
    input logic              rd1_misalign,
    input store_t            mem_q
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (bank_q == 1'b0 && mem_q == '0));

    a_r10_bank_load: assert property (@(posedge clk) disable iff (rst)
        bank_ld |=> bank_q == $past(bank_d));

    a_r10_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !bank_ld |=> $stable(bank_q));

    a_r8_bad_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_misalign) |=> $stable(mem_q));

    a_r7_rd0_zero: assert property (@(posedge clk) disable iff (rst)
        rd0_misalign |-> rd0_data == '0);

    a_r7_rd1_zero: assert property (@(posedge clk) disable iff (rst)
        rd1_misalign |-> rd1_data == '0);

    a_r9_idle_no_change: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem_q));
endmodule

bind banked_fpr_file banked_fpr_file_chk u_chk (
    .clk(clk), .rst(rst), .bank_ld(bank_ld), .bank_d(bank_d), .bank_q(bank_q),
    .wr_en(wr_en), .wr_misalign(wr_misalign),
    .rd0_data(rd0_data), .rd0_misalign(rd0_misalign),
    .rd1_data(rd1_data), .rd1_misalign(rd1_misalign),
    .mem_q(mem_q)
);

// File: tb/banked_fpr_file_tb.sv
module banked_fpr_file_tb;
    import fprf_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bank_ld = 1'b0, bank_d = 1'b0, bank_q;
    logic wr_en = 1'b0;
    logic [2:0] wr_view = 3'd0, rd0_view = 3'd0, rd1_view = 3'd0;
    logic [3:0] wr_idx = 4'd0, rd0_idx = 4'd0, rd1_idx = 4'd0;
    logic [127:0] wr_data = '0, rd0_data, rd1_data;
    logic wr_misalign, rd0_misalign, rd1_misalign;
    logic [511:0] mtx_data;

    int n_chk = 0, n_bad = 0;
    logic [31:0] m_mem [32];
    logic m_bank = 1'b0;

    always #2 clk = ~clk;

    banked_fpr_file u_dut (
        .clk(clk), .rst(rst), .bank_ld(bank_ld), .bank_d(bank_d), .bank_q(bank_q),
        .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_misalign(wr_misalign),
        .rd0_view(rd0_view), .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd0_misalign(rd0_misalign),
        .rd1_view(rd1_view), .rd1_idx(rd1_idx), .rd1_data(rd1_data), .rd1_misalign(rd1_misalign),
        .mtx_data(mtx_data)
    );

    task automatic check(string req, logic [511:0] got, logic [511:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int view_words(logic [2:0] v);
        case (v)
            3'd1, 3'd4: return 2;
            3'd2:       return 4;
            default:    return 1;
        endcase
    endfunction

    function automatic logic view_bad(logic [2:0] v, logic [3:0] i);
        case (v)
            3'd0, 3'd3: return 1'b0;
            3'd1, 3'd4: return i[0];
            3'd2:       return i[1:0] != 2'b00;
            default:    return 1'b1;
        endcase
    endfunction

    function automatic int phys(logic [2:0] v, logic [3:0] i, int w);
        logic b;
        b = (v == 3'd3 || v == 3'd4) ? ~m_bank : m_bank;
        return (b ? 16 : 0) + int'(i) + w;
    endfunction

    function automatic logic [127:0] exp_read(logic [2:0] v, logic [3:0] i);
        logic [127:0] d;
        int nw;
        d = '0;
        nw = view_words(v);
        if (!view_bad(v, i))
            for (int w = 0; w < nw; w++) d[(nw - 1 - w) * 32 +: 32] = m_mem[phys(v, i, w)];
        return d;
    endfunction

    function automatic logic [511:0] exp_mtx();
        logic [511:0] m;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                m[511 - 32 * (4 * r + c) -: 32] = m_mem[(m_bank ? 0 : 16) + r + 4 * c];
        return m;
    endfunction

    task automatic model_write(logic [2:0] v, logic [3:0] i, logic [127:0] d);
        int nw;
        nw = view_words(v);
        if (!view_bad(v, i))
            for (int w = 0; w < nw; w++) m_mem[phys(v, i, w)] = d[(nw - 1 - w) * 32 +: 32];
    endtask

    task automatic do_write(logic [2:0] v, logic [3:0] i, logic [127:0] d, string req);
        @(negedge clk);
        wr_en = 1'b1; wr_view = v; wr_idx = i; wr_data = d;
        #1 check(req, {511'd0, wr_misalign}, {511'd0, view_bad(v, i)});
        @(posedge clk);
        model_write(v, i, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(logic [2:0] v0, logic [3:0] i0, logic [2:0] v1, logic [3:0] i1, string req);
        @(negedge clk);
        rd0_view = v0; rd0_idx = i0; rd1_view = v1; rd1_idx = i1;
        #1;
        check(req, {384'd0, rd0_data}, {384'd0, exp_read(v0, i0)});
        check(req, {384'd0, rd1_data}, {384'd0, exp_read(v1, i1)});
        check(req, {510'd0, rd0_misalign, rd1_misalign}, {510'd0, view_bad(v0, i0), view_bad(v1, i1)});
    endtask

    task automatic set_bank(logic b);
        @(negedge clk);
        bank_ld = 1'b1; bank_d = b;
        @(posedge clk);
        m_bank = b;
        @(negedge clk);
        bank_ld = 1'b0;
    endtask

    task automatic t_reset();
        for (int k = 0; k < 32; k++) m_mem[k] = '0;
        check("R1 bank", {511'd0, bank_q}, 512'd0);
        check("R1 matrix", mtx_data, 512'd0);
        for (int i = 0; i < 16; i += 4) do_read(3'd2, 4'(i), 3'd0, 4'(i + 1), "R1 contents");
    endtask

    task automatic t_singles();
        for (int i = 0; i < 16; i++) do_write(3'd0, 4'(i), {96'd0, 32'h1000_0000 + i}, "R9 single write");
        set_bank(1'b1);
        check("R10 bank_q", {511'd0, bank_q}, {511'd0, 1'b1});
        for (int i = 0; i < 16; i++) do_write(3'd0, 4'(i), {96'd0, 32'h2000_0000 + i}, "R9 single write b1");
        for (int i = 0; i < 16; i++) do_read(3'd0, 4'(i), 3'd3, 4'(i), "R2 R3 single vs extended");
        set_bank(1'b0);
        for (int i = 0; i < 16; i += 3) do_read(3'd3, 4'(i), 3'd0, 4'(i), "R3 R2 after swap");
    endtask

    task automatic t_pairs_quads();
        do_write(3'd1, 4'd6, 128'h0_AAAA_0006_BBBB_0007, "R4 pair write");
        do_write(3'd4, 4'd14, 128'h0_CCCC_000E_DDDD_000F, "R4 xpair write");
        do_write(3'd2, 4'd8, 128'h1111_0008_2222_0009_3333_000A_4444_000B, "R5 quad write");
        for (int i = 0; i < 16; i += 2) do_read(3'd1, 4'(i), 3'd4, 4'(i), "R4 pair reads");
        for (int i = 0; i < 16; i += 4) do_read(3'd2, 4'(i), 3'd0, 4'(i + 3), "R5 quad reads R11");
        do_read(3'd0, 4'd9, 3'd2, 4'd8, "R11 independent ports");
    endtask

    task automatic t_matrix();
        @(negedge clk);
        check("R6 matrix bank0", mtx_data, exp_mtx());
        set_bank(1'b1);
        #1 check("R6 matrix bank1", mtx_data, exp_mtx());
        set_bank(1'b0);
    endtask

    task automatic t_misalign();
        do_write(3'd1, 4'd3, {128{1'b1}}, "R8 odd pair write");
        do_write(3'd2, 4'd6, {128{1'b1}}, "R8 quad write at 6");
        do_write(3'd5, 4'd0, {128{1'b1}}, "R8 reserved view write");
        for (int i = 0; i < 16; i += 4) do_read(3'd2, 4'(i), 3'd4, 4'(i), "R8 storage intact");
        @(negedge clk);
        check("R8 matrix intact", mtx_data, exp_mtx());
        do_read(3'd1, 4'd5, 3'd2, 4'd2, "R7 misaligned reads");
        do_read(3'd4, 4'd1, 3'd7, 4'd0, "R7 xpair odd / reserved");
    endtask

    task automatic t_rd_during_wr();
        logic [127:0] old;
        @(negedge clk);
        old = exp_read(3'd0, 4'd5);
        wr_en = 1'b1; wr_view = 3'd0; wr_idx = 4'd5; wr_data = {96'd0, 32'hFEED_0005};
        rd0_view = 3'd0; rd0_idx = 4'd5;
        #1 check("R9 old value before edge", {384'd0, rd0_data}, {384'd0, old});
        @(posedge clk);
        model_write(3'd0, 4'd5, {96'd0, 32'hFEED_0005});
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R9 new value after edge", {384'd0, rd0_data}, {480'd0, 32'hFEED_0005});
    endtask

    task automatic t_bank_switch();
        @(negedge clk);
        bank_ld = 1'b1; bank_d = 1'b1;
        rd0_view = 3'd0; rd0_idx = 4'd2; rd1_view = 3'd3; rd1_idx = 4'd2;
        #1;
        check("R10 same-cycle old map", {384'd0, rd0_data}, {384'd0, exp_read(3'd0, 4'd2)});
        check("R10 same-cycle old xmap", {384'd0, rd1_data}, {384'd0, exp_read(3'd3, 4'd2)});
        @(posedge clk);
        m_bank = 1'b1;
        #1;
        check("R10 new map", {384'd0, rd0_data}, {384'd0, exp_read(3'd0, 4'd2)});
        check("R10 new xmap", {384'd0, rd1_data}, {384'd0, exp_read(3'd3, 4'd2)});
        @(negedge clk);
        bank_ld = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_singles();
        t_pairs_quads();
        t_matrix();
        t_misalign();
        t_rd_during_wr();
        t_bank_switch();
        finish_run();
    end
endmodule